// File: doc/BRIEF.md
# Double-Buffered Timer Update Controller

This block is a 16-bit timer/counter whose period and four compare/capture channel values are staged through software-written shadow registers. Each of the five shadow registers carries its own pending flag. When an update event occurs, every shadow register with its pending flag set is copied into the live register that the counter and the channels use, and the flag is cleared. An update event occurs naturally at the end of a count cycle, or at once when software issues a command. A lock bit lets software stage several values and hold the copy back until all of them are ready.

Software reaches the block through a simple synchronous register bus with a write strobe and a combinational read port. The pending flags have a set address and a clear address. A write-only two-bit command field issues update, restart and hard-reset strobes, and the count direction can be written directly. With capture mode enabled, each channel's strobe input stores the current count in that channel's shadow register. The pending flag then serves as a "capture holds data" marker, tied to a per-channel capture flag.

Top module: `tmr_dbuf_ctrl`

## Requirements
- R1: After reset every readable location returns zero. The address map is: 0 control (bit 0 run, bit 1 capture mode), 1 mode (bit 0 direction, bit 1 lock, bits 3:2 command), 2 flag clear, 3 flag set, 4 capture flags, 5 count, 8+k live register k, 16+k shadow register k, where k=0 is the period and k=1..4 are channels A..D. Unused addresses read zero.
- R2: A write to shadow address 16+k stores the data there and sets pending flag k. Addresses 2 and 3 both read the flags with bit k = slot k, and bits 15:5 read zero.
- R3: Writing ones to address 3 sets the selected pending flags. Writing ones to address 2 clears them. Zero bits leave flags unchanged.
- R4: Command 01 forces an update in the cycle of the write. Every slot with its flag set copies its shadow value to its live register and clears its flag. Slots without a flag keep their live value.
- R5: While run is 1 the count steps once per clock. Counting up, it goes from the live period value back to 0, and that cycle is an update event. Counting down, it goes from 0 back to the live period value, and that cycle is an update event.
- R6: While lock is 1 and capture mode is off, no update event copies any slot, and all pending flags stay set. The command in a mode write is judged against the lock value held before that write.
- R7: The command bits read back as zero. The direction bit reads back as written: 0 means up, 1 means down.
- R8: Command 10 clears the count and sets the direction to up, overriding the direction bit written in the same access. Live values, shadow values and flags are unchanged.
- R9: Command 11 returns every register to zero when run is 0. It has no effect while run is 1.
- R10: In capture mode, a pulse on cap_strobe[c] stores the count into shadow register c+1 and sets pending flag c+1 and capture flag c (address 4, bit c). Outside capture mode the strobes change nothing.
- R11: In capture mode the channel slots are never copied by an update, and writing 1 to bit c of address 4 clears capture flag c and pending flag c+1. The lock bit has no effect in capture mode: the period slot is still copied.
- R12: When a shadow write coincides with an update that copies the same slot, the live register takes the old shadow value, the shadow register takes the new data, and the pending flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| cap_strobe | input | 4 | Per-channel capture strobe, one bit per channel A..D |

## Verification
The hazard is a natural end-of-count update that falls in the same clock as a software write to a shadow register of a slot that is about to be copied. The bench makes this happen on purpose: it waits until its own model shows the count standing at the period value, then issues the shadow write in exactly that cycle. It then judges R12 by reading the live value (old data), the shadow value (new data) and the pending flag (set). A second pairing is a restart command carried by a mode write whose direction bit is 1. After that access the direction must read up and the count must read zero.

// File: rtl/tmr_dbuf_pkg.sv
package tmr_dbuf_pkg;

    localparam int TD_DATA_W   = 16;
    localparam int TD_NCH      = 4;
    localparam int TD_ADDR_W   = 5;

    // register map
    localparam int TD_A_CTRL   = 0;
    localparam int TD_A_MODE   = 1;
    localparam int TD_A_FCLR   = 2;
    localparam int TD_A_FSET   = 3;
    localparam int TD_A_CAPF   = 4;
    localparam int TD_A_CNT    = 5;
    localparam int TD_ACT_BASE = 8;
    localparam int TD_BUF_BASE = 16;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_UPD     = 2'b01,
        CMD_RESTART = 2'b10,
        CMD_HARD    = 2'b11
    } td_cmd_e;

    // decoded bus access for one cycle
    typedef struct packed {
        logic    ctrl_we;
        logic    mode_we;
        td_cmd_e cmd;
        logic    fclr_we;
        logic    fset_we;
        logic    capf_we;
    } td_dec_t;

    // control state held by the counter core
    typedef struct packed {
        logic run;
        logic capm;
        logic lock;
        logic dir;
    } td_ctl_t;

    function automatic logic td_hit(input int addr, input int base, input int idx);
        return addr == base + idx;
    endfunction

endpackage

// File: rtl/tmr_dbuf_regif.sv
module tmr_dbuf_regif
    import tmr_dbuf_pkg::*;
#(
    parameter int DATA_W = TD_DATA_W,
    parameter int ADDR_W = TD_ADDR_W,
    parameter int NCH    = TD_NCH,
    parameter int NSLOT  = TD_NCH + 1
) (
    input  logic                             bus_we,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    input  td_ctl_t                          ctl,
    input  logic [NSLOT-1:0]                 vld,
    input  logic [NCH-1:0]                   irq,
    input  logic [DATA_W-1:0]                cnt,
    input  logic [NSLOT-1:0][DATA_W-1:0]     act,
    input  logic [NSLOT-1:0][DATA_W-1:0]     shd,
    output td_dec_t                          dec,
    output logic [NSLOT-1:0]                 shd_we,
    output logic [DATA_W-1:0]                rdata
);

    logic [31:0] addr_i;
    assign addr_i = 32'(bus_addr);

    always_comb begin
        dec = '0;
        if (bus_we) begin
            dec.ctrl_we = (int'(addr_i) == TD_A_CTRL);
            dec.mode_we = (int'(addr_i) == TD_A_MODE);
            dec.fclr_we = (int'(addr_i) == TD_A_FCLR);
            dec.fset_we = (int'(addr_i) == TD_A_FSET);
            dec.capf_we = (int'(addr_i) == TD_A_CAPF);
            if (int'(addr_i) == TD_A_MODE) begin
                dec.cmd = td_cmd_e'(bus_wdata[3:2]);
            end
        end
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_swe
        assign shd_we[k] = bus_we && td_hit(int'(addr_i), TD_BUF_BASE, k);
    end

    always_comb begin
        rdata = '0;
        case (int'(addr_i))
            TD_A_CTRL:            rdata[1:0]       = {ctl.capm, ctl.run};
            TD_A_MODE:            rdata[1:0]       = {ctl.lock, ctl.dir};
            TD_A_FCLR, TD_A_FSET: rdata[NSLOT-1:0] = vld;
            TD_A_CAPF:            rdata[NCH-1:0]   = irq;
            TD_A_CNT:             rdata            = cnt;
            default:              ;
        endcase
        for (int k = 0; k < NSLOT; k++) begin
            if (td_hit(int'(addr_i), TD_ACT_BASE, k)) rdata = act[k];
            if (td_hit(int'(addr_i), TD_BUF_BASE, k)) rdata = shd[k];
        end
    end

endmodule

// File: rtl/tmr_dbuf_core.sv
module tmr_dbuf_core
    import tmr_dbuf_pkg::*;
#(
    parameter int DATA_W = TD_DATA_W,
    parameter int NCH    = TD_NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  td_dec_t           dec,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] per,
    input  logic [NCH-1:0]    cap_strobe,
    output td_ctl_t           ctl,
    output logic [DATA_W-1:0] cnt,
    output logic [NCH-1:0]    irq,
    output logic              hard_rst,
    output logic              upd_evt
);

    logic              at_end;
    logic              restart;
    logic [DATA_W-1:0] cnt_nxt;
    td_ctl_t           ctl_nxt;
    logic [NCH-1:0]    irq_set;
    logic [NCH-1:0]    irq_clr;

    assign at_end   = ctl.dir ? (cnt == '0) : (cnt == per);
    assign restart  = (dec.cmd == CMD_RESTART);
    assign hard_rst = (dec.cmd == CMD_HARD) && !ctl.run;
    assign upd_evt  = (ctl.run && at_end) || (dec.cmd == CMD_UPD);

    assign irq_set = ctl.capm ? cap_strobe : '0;
    assign irq_clr = dec.capf_we ? wdata[NCH-1:0] : '0;

    always_comb begin
        cnt_nxt = cnt;
        if (restart) begin
            cnt_nxt = '0;
        end else if (ctl.run) begin
            if (!ctl.dir) cnt_nxt = at_end ? '0  : cnt + 1'b1;
            else          cnt_nxt = at_end ? per : cnt - 1'b1;
        end
    end

    always_comb begin
        ctl_nxt = ctl;
        if (dec.ctrl_we) begin
            ctl_nxt.run  = wdata[0];
            ctl_nxt.capm = wdata[1];
        end
        if (dec.mode_we) begin
            ctl_nxt.dir  = wdata[0];
            ctl_nxt.lock = wdata[1];
        end
        if (restart) ctl_nxt.dir = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || hard_rst) begin
            ctl <= '0;
            cnt <= '0;
            irq <= '0;
        end else begin
            ctl <= ctl_nxt;
            cnt <= cnt_nxt;
            irq <= (irq & ~irq_clr) | irq_set;
        end
    end

endmodule

// File: rtl/tmr_dbuf_slot.sv
module tmr_dbuf_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_rst,
    input  logic              xfer_en,
    input  logic              shd_we,
    input  logic              cap_evt,
    input  logic              flag_set,
    input  logic              flag_clr,
    input  logic              irq_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] act,
    output logic [DATA_W-1:0] shd,
    output logic              valid
);

    logic valid_nxt;

    // set sources win over every clear source
    always_comb begin
        valid_nxt = valid;
        if (xfer_en)  valid_nxt = 1'b0;
        if (flag_clr) valid_nxt = 1'b0;
        if (irq_clr)  valid_nxt = 1'b0;
        if (shd_we || cap_evt || flag_set) valid_nxt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || hard_rst) begin
            act   <= '0;
            shd   <= '0;
            valid <= 1'b0;
        end else begin
            if (xfer_en && valid) act <= shd;
            if (shd_we)       shd <= wdata;
            else if (cap_evt) shd <= cnt;
            valid <= valid_nxt;
        end
    end

endmodule

// File: rtl/tmr_dbuf_ctrl.sv
module tmr_dbuf_ctrl
    import tmr_dbuf_pkg::*;
#(
    parameter int DATA_W = TD_DATA_W,
    parameter int ADDR_W = TD_ADDR_W,
    parameter int NCH    = TD_NCH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    cap_strobe
);

    localparam int NSLOT = NCH + 1;

    td_dec_t                      dec;
    td_ctl_t                      ctl_q;
    logic [DATA_W-1:0]            cnt_q;
    logic [NCH-1:0]               irq_q;
    logic                         hard_rst;
    logic                         upd_evt;
    logic [NSLOT-1:0]             shd_we;
    logic [NSLOT-1:0]             vld_q;
    logic [NSLOT-1:0]             xfer_en;
    logic [NSLOT-1:0]             cap_evt;
    logic [NSLOT-1:0]             irq_clr;
    logic [NSLOT-1:0]             flag_set;
    logic [NSLOT-1:0]             flag_clr;
    logic [NSLOT-1:0][DATA_W-1:0] act_q;
    logic [NSLOT-1:0][DATA_W-1:0] shd_q;

    tmr_dbuf_regif #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NCH    (NCH),
        .NSLOT  (NSLOT)
    ) u_regif (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctl       (ctl_q),
        .vld       (vld_q),
        .irq       (irq_q),
        .cnt       (cnt_q),
        .act       (act_q),
        .shd       (shd_q),
        .dec       (dec),
        .shd_we    (shd_we),
        .rdata     (bus_rdata)
    );

    tmr_dbuf_core #(
        .DATA_W (DATA_W),
        .NCH    (NCH)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .wdata      (bus_wdata),
        .per        (act_q[0]),
        .cap_strobe (cap_strobe),
        .ctl        (ctl_q),
        .cnt        (cnt_q),
        .irq        (irq_q),
        .hard_rst   (hard_rst),
        .upd_evt    (upd_evt)
    );

    assign flag_set = dec.fset_we ? bus_wdata[NSLOT-1:0] : '0;
    assign flag_clr = dec.fclr_we ? bus_wdata[NSLOT-1:0] : '0;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        if (k == 0) begin : g_per
            // period slot: lock is ignored in capture mode
            assign xfer_en[k] = upd_evt && (!ctl_q.lock || ctl_q.capm);
            assign cap_evt[k] = 1'b0;
            assign irq_clr[k] = 1'b0;
        end else begin : g_chan
            assign xfer_en[k] = upd_evt && !ctl_q.lock && !ctl_q.capm;
            assign cap_evt[k] = ctl_q.capm && cap_strobe[k-1];
            assign irq_clr[k] = ctl_q.capm && dec.capf_we && bus_wdata[k-1];
        end

        tmr_dbuf_slot #(
            .DATA_W (DATA_W)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .hard_rst (hard_rst),
            .xfer_en  (xfer_en[k]),
            .shd_we   (shd_we[k]),
            .cap_evt  (cap_evt[k]),
            .flag_set (flag_set[k]),
            .flag_clr (flag_clr[k]),
            .irq_clr  (irq_clr[k]),
            .wdata    (bus_wdata),
            .cnt      (cnt_q),
            .act      (act_q[k]),
            .shd      (shd_q[k]),
            .valid    (vld_q[k])
        );
    end

endmodule

// File: rtl/tmr_dbuf_chk.sv
module tmr_dbuf_chk
    import tmr_dbuf_pkg::*;
#(
    parameter int DATA_W = TD_DATA_W,
    parameter int ADDR_W = TD_ADDR_W,
    parameter int NSLOT  = TD_NCH + 1
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_we,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic                         run,
    input logic                         lock,
    input logic                         dir,
    input logic [DATA_W-1:0]            cnt,
    input logic [NSLOT-1:0][DATA_W-1:0] act
);

    logic mode_wr;
    assign mode_wr = bus_we && (int'(bus_addr) == TD_A_MODE);

    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == TD_A_MODE) |-> (bus_rdata[3:2] == 2'b00)); // R7

    AST_FLAG_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == TD_A_FCLR || int'(bus_addr) == TD_A_FSET)
        |-> (bus_rdata[DATA_W-1:NSLOT] == '0)); // R2

    AST_LOCK_HOLDS_CHANNELS: assert property (@(posedge clk) disable iff (rst)
        (lock && !(mode_wr && bus_wdata[3:2] == 2'b11))
        |=> $stable(act[NSLOT-1:1])); // R6

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && bus_wdata[3:2] == 2'b10) |=> (cnt == '0 && !dir)); // R8

    AST_HARD_IGNORED_RUNNING: assert property (@(posedge clk) disable iff (rst)
        (run && mode_wr && bus_wdata[3:2] == 2'b11) |=> run); // R9

    AST_HARD_CLEARS_OFF: assert property (@(posedge clk) disable iff (rst)
        (!run && mode_wr && bus_wdata[3:2] == 2'b11) |=> (cnt == '0 && act == '0)); // R9

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && !dir && cnt == act[0] && !mode_wr) |=> (cnt == '0)); // R5

endmodule

bind tmr_dbuf_ctrl tmr_dbuf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .run       (ctl_q.run),
    .lock      (ctl_q.lock),
    .dir       (ctl_q.dir),
    .cnt       (cnt_q),
    .act       (act_q)
);

// File: tb/tmr_dbuf_ctrl_bench.sv
module tmr_dbuf_ctrl_bench;

    localparam int NS = 5;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  cap_s = '0;

    int errs = 0;
    int checks = 0;
    bit cmp_on = 0;
    bit done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    tmr_dbuf_ctrl u_tmr_dbuf_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (we),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .cap_strobe (cap_s)
    );

    // ---------------- behavioural reference model ----------------
    int m_run, m_capm, m_lock, m_dir, m_cnt;
    int m_act [NS];
    int m_buf [NS];
    int m_vld [NS];
    int m_irq [NC];
    int a_i, d_i, cmd, o_cnt, o_per, v;
    bit hard, rest, upd, nat, xf, cap, wrb;

    function automatic void m_clear();
        m_run = 0; m_capm = 0; m_lock = 0; m_dir = 0; m_cnt = 0;
        for (int k = 0; k < NS; k++) begin
            m_act[k] = 0; m_buf[k] = 0; m_vld[k] = 0;
        end
        for (int c = 0; c < NC; c++) m_irq[c] = 0;
    endfunction

    function automatic int m_read(int a);
        int r = 0;
        if (a == 0)                 r = m_run | (m_capm << 1);
        else if (a == 1)            r = m_dir | (m_lock << 1);
        else if (a == 2 || a == 3)  for (int k = 0; k < NS; k++) r |= m_vld[k] << k;
        else if (a == 4)            for (int c = 0; c < NC; c++) r |= m_irq[c] << c;
        else if (a == 5)            r = m_cnt;
        else if (a >= 8 && a < 8 + NS)   r = m_act[a - 8];
        else if (a >= 16 && a < 16 + NS) r = m_buf[a - 16];
        return r;
    endfunction

    always @(posedge clk) begin
        a_i = int'(addr);
        d_i = int'(wdata);
        if (rst) begin
            m_clear();
        end else begin
            cmd  = (we && a_i == 1) ? ((d_i >> 2) & 3) : 0;
            hard = (cmd == 3) && (m_run == 0);
            rest = (cmd == 2);
            nat  = (m_run != 0) && ((m_dir == 0 && m_cnt == m_act[0]) ||
                                    (m_dir != 0 && m_cnt == 0));
            upd  = nat || (cmd == 1);
            o_cnt = m_cnt;
            o_per = m_act[0];
            if (hard) begin
                m_clear();
            end else begin
                for (int k = 0; k < NS; k++) begin
                    if (k == 0) xf = upd && (m_lock == 0 || m_capm != 0);
                    else        xf = upd && m_lock == 0 && m_capm == 0;
                    cap = 0;
                    if (k > 0) cap = (m_capm != 0) && cap_s[k-1];
                    wrb = we && (a_i == 16 + k);
                    if (xf && m_vld[k] != 0) m_act[k] = m_buf[k];
                    v = m_vld[k];
                    if (xf) v = 0;
                    if (we && a_i == 2 && ((d_i >> k) & 1) != 0) v = 0;
                    if (k > 0 && m_capm != 0 && we && a_i == 4 && ((d_i >> (k-1)) & 1) != 0) v = 0;
                    if (wrb || cap || (we && a_i == 3 && ((d_i >> k) & 1) != 0)) v = 1;
                    m_vld[k] = v;
                    if (wrb)      m_buf[k] = d_i & 16'hFFFF;
                    else if (cap) m_buf[k] = o_cnt;
                end
                for (int c = 0; c < NC; c++) begin
                    if (we && a_i == 4 && ((d_i >> c) & 1) != 0) m_irq[c] = 0;
                    if (m_capm != 0 && cap_s[c]) m_irq[c] = 1;
                end
                if (rest) m_cnt = 0;
                else if (m_run != 0) begin
                    if (m_dir == 0) m_cnt = (m_cnt == o_per) ? 0 : ((m_cnt + 1) & 16'hFFFF);
                    else            m_cnt = (m_cnt == 0) ? o_per : (m_cnt - 1);
                end
                if (we && a_i == 1) begin
                    m_dir  = d_i & 1;
                    m_lock = (d_i >> 1) & 1;
                end
                if (rest) m_dir = 0;
                if (we && a_i == 0) begin
                    m_run  = d_i & 1;
                    m_capm = (d_i >> 1) & 1;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        int exp;
        #2;
        if (cmp_on && !done) begin
            exp = m_read(int'(addr));
            checks++;
            if (rdata !== exp[15:0]) begin
                errs++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", cur_req, addr, rdata, exp[15:0]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        we = 1'b1; addr = 5'(a); wdata = 16'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a);
        @(negedge clk);
        we = 1'b0; addr = 5'(a);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic watch(input int a, input int n);
        rd(a);
        idle(n);
    endtask

    task automatic pulse(input int c);
        @(negedge clk);
        cap_s = 4'(1 << c);
        @(negedge clk);
        cap_s = '0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp_on = 1;

        cur_req = "R1";
        for (int a = 0; a < 24; a++) rd(a);

        cur_req = "R2";
        wr(16, 16'h1234);
        wr(18, 16'hBEEF);
        rd(2); rd(3); rd(16); rd(18); rd(8); rd(10);

        cur_req = "R4";
        wr(1, 32'h4);
        rd(8); rd(10); rd(9); rd(2);

        cur_req = "R3";
        wr(3, 16'hFFFF);
        rd(3);
        wr(2, 16'h0005);
        rd(2);
        wr(1, 32'h4);
        rd(2); rd(9); rd(11);

        cur_req = "R6";
        wr(17, 16'h1111);
        wr(16, 16'h0040);
        wr(1, 32'h2);
        wr(1, 32'h2 | 32'h4);
        rd(9); rd(8); rd(2);
        cur_req = "R4";
        wr(1, 32'h0);
        wr(1, 32'h4);
        rd(9); rd(8); rd(2);

        cur_req = "R7";
        wr(1, 32'h1);
        rd(1);
        wr(1, 32'h1 | 32'h4);
        rd(1);

        cur_req = "R5";
        wr(16, 3);
        wr(1, 32'h4);
        wr(17, 16'h0077);
        wr(0, 1);
        watch(5, 12);
        rd(9); rd(2);
        wr(1, 32'h1);
        watch(5, 12);

        cur_req = "R9";
        wr(1, 32'hD);
        rd(0); rd(8); rd(1);
        watch(5, 4);

        cur_req = "R8";
        wr(1, 32'h8 | 32'h1);
        rd(1);
        watch(5, 6);
        rd(8);

        cur_req = "R12";
        wr(16, 20);
        wr(1, 32'h4);
        wr(17, 16'h0AAA);
        @(negedge clk);
        while (m_cnt != 20) @(negedge clk);
        we = 1'b1; addr = 5'(17); wdata = 16'h0BBB;
        @(negedge clk);
        we = 1'b0;
        rd(9); rd(17); rd(2); rd(8);

        cur_req = "R10";
        wr(0, 3);
        idle(3);
        pulse(0);
        idle(2);
        pulse(2);
        rd(17); rd(19); rd(4); rd(2);

        cur_req = "R11";
        wr(16, 7);
        wr(1, 32'h2);
        watch(8, 30);
        rd(2); rd(9); rd(11);
        wr(4, 1);
        rd(4); rd(2);

        cur_req = "R10";
        wr(0, 1);
        pulse(3);
        rd(20); rd(4); rd(2);

        cur_req = "R9";
        wr(0, 0);
        wr(1, 32'hC);
        for (int a = 0; a < 24; a++) rd(a);

        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule